// File: doc/BRIEF.md
# One-Shot ADC Scan Sequencer

This block is the control sequencer of an analog-to-digital converter in scan mode. A scan is requested by setting a start bit. Software can set it through a register write, either of two timer trigger inputs can set it, and so can an external trigger input. The block then converts a group of one to four consecutive channels, in ascending channel order. For each channel it issues a one-cycle convert request to an external converter core and waits for that core's done pulse. The returned 10-bit sample goes into a result register that belongs to that channel alone.

When the last channel of the group has been stored, the block sets a completion flag. It raises an interrupt while the flag and the interrupt enable are both set. With auto-clear on, hardware drops the start bit and the block goes back to waiting. With auto-clear off, the start bit stays set and the group is scanned again until software clears the bit. Software reads and writes a single control word and reads the result registers through a plain address/data port.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control word reads 0, every result register reads 0, `irq` is 0 and `cnv_req` is 0.
- R2: A control write with start (bit 0) set is captured at edge k while idle. The first `cnv_req` is then high in the cycle after edge k+1, and it carries the group's first channel.
- R3: A one-cycle pulse on `tmr_trig[0]`, `tmr_trig[1]` or `ext_trig` while idle starts a scan, exactly as a software start does.
- R4: With the scan field (bits 5:4) at 2'b10, the channels converted run from base to base+count in ascending order. The base is the group field (bits 7:6) times 4, taken modulo the channel count, so group 2'b01 starts at channel 4. The count is the count field (bits 9:8).
- R5: With the scan field at any value other than 2'b10, only the base channel is converted.
- R6: Each `cnv_data` value returned with `cnv_done` is stored in the result register of the channel requested, which reads at address 8 + channel.
- R7: The completion flag (bit 1) is set only when the last channel of the group completes. `irq` is high only while the flag and the interrupt enable (bit 2) are both 1.
- R8: With auto-clear (bit 3) at 1, the start bit reads 0 once the last channel completes, and no further request follows.
- R9: With auto-clear at 0, the start bit stays 1 and the group is scanned again. After software writes start as 0, the pass in progress completes and no new pass begins.
- R10: While a pass runs, trigger pulses and control writes neither restart the pass nor change its channels. A start bit written as 1 during the pass is not taken.
- R11: Writing 0 to the flag bit clears the flag. Writing 1 to it leaves the flag unchanged.
- R12: The sequencer waits any number of cycles for `cnv_done`. Each request lasts one cycle, and the next channel's request follows in the cycle after the previous done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (0 = control word) |
| wr_data | input | 10 | Write data |
| rd_addr | input | 4 | Read address (0 = control word, 8..15 = results) |
| rd_data | output | 10 | Read data, combinational |
| tmr_trig | input | 2 | Timer start triggers, one-cycle pulses |
| ext_trig | input | 1 | External start trigger, one-cycle pulse |
| cnv_req | output | 1 | One-cycle convert request |
| cnv_ch | output | 3 | Channel for the request |
| cnv_done | input | 1 | One-cycle conversion complete |
| cnv_data | input | 10 | Sample returned with `cnv_done` |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its defaults: eight channels, 10-bit samples and two timer triggers. Both channel groups and every group length from one to four are therefore reachable, including the upper group that starts at channel 4. A bench converter model with a latency that can be changed at run time gives both back-to-back conversions and long waits. That brings the one-cycle request spacing and the protection against triggers during a pass within reach. It also covers repeated passes with auto-clear off and the end of those passes after software clears the start bit.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int CTRL_W = 10;
  localparam int CNT_W  = 2;

  localparam int B_START = 0;
  localparam int B_FLAG  = 1;
  localparam int B_IRQEN = 2;
  localparam int B_ACLR  = 3;
  localparam int B_MODE  = 4;
  localparam int B_GRP   = 6;
  localparam int B_CNT   = 8;

  localparam logic [1:0] MODE_SCAN = 2'b10;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [1:0]       grp;
    logic [1:0]       mode;
    logic             aclr;
    logic             irq_en;
  } cfg_t;

endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              trig_any,
  input  logic              busy,
  input  logic              pass_end,
  output logic              start_q,
  output logic              flag_q,
  output cfg_t              cfg_q,
  output logic [CTRL_W-1:0] ctrl_rd
);

  logic start_d, flag_d, reg_en;
  cfg_t cfg_d;

  assign reg_en = ctrl_wr | trig_any | pass_end;

  always_comb begin
    start_d = start_q;
    flag_d  = flag_q;
    cfg_d   = cfg_q;
    if (ctrl_wr) begin
      cfg_d.cnt    = wr_data[B_CNT +: CNT_W];
      cfg_d.grp    = wr_data[B_GRP +: 2];
      cfg_d.mode   = wr_data[B_MODE +: 2];
      cfg_d.aclr   = wr_data[B_ACLR];
      cfg_d.irq_en = wr_data[B_IRQEN];
      // software may always clear start, but may set it only while idle
      if (!wr_data[B_START])
        start_d = 1'b0;
      else if (!busy)
        start_d = 1'b1;
      if (!wr_data[B_FLAG])
        flag_d = 1'b0;
    end
    if (trig_any && !busy)
      start_d = 1'b1;
    // hardware completion has the last word
    if (pass_end) begin
      flag_d = 1'b1;
      if (cfg_q.aclr)
        start_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      flag_q  <= 1'b0;
      cfg_q   <= '0;
    end else if (reg_en) begin
      start_q <= start_d;
      flag_q  <= flag_d;
      cfg_q   <= cfg_d;
    end
  end

  always_comb begin
    ctrl_rd                   = '0;
    ctrl_rd[B_START]          = start_q;
    ctrl_rd[B_FLAG]           = flag_q;
    ctrl_rd[B_IRQEN]          = cfg_q.irq_en;
    ctrl_rd[B_ACLR]           = cfg_q.aclr;
    ctrl_rd[B_MODE +: 2]      = cfg_q.mode;
    ctrl_rd[B_GRP +: 2]       = cfg_q.grp;
    ctrl_rd[B_CNT +: CNT_W]   = cfg_q.cnt;
  end

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_q,
  input  cfg_t            cfg_q,
  input  logic            cnv_done,
  output logic            cnv_req,
  output logic [CH_W-1:0] cnv_ch,
  output logic            busy,
  output logic            pass_end,
  output logic            res_we
);

  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] cur_q, cur_d, last_q, last_d;
  logic [CH_W-1:0] base_ch;
  logic [CNT_W-1:0] span;
  logic            at_last;

  // group base is the group number times the maximum group size
  assign base_ch = CH_W'({cfg_q.grp, {CNT_W{1'b0}}});
  assign span    = (cfg_q.mode == MODE_SCAN) ? cfg_q.cnt : '0;
  assign at_last = (cur_q == last_q);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    last_d  = last_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_q) begin
          state_d = S_REQ;
          cur_d   = base_ch;
          last_d  = base_ch + CH_W'(span);
        end
      end
      S_REQ: state_d = S_WAIT;
      S_WAIT: begin
        if (cnv_done) begin
          if (at_last) begin
            state_d = S_IDLE;
          end else begin
            state_d = S_REQ;
            cur_d   = cur_q + 1'b1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      last_q  <= last_d;
    end
  end

  assign cnv_req  = (state_q == S_REQ);
  assign cnv_ch   = cur_q;
  assign busy     = (state_q != S_IDLE);
  assign res_we   = (state_q == S_WAIT) && cnv_done;
  assign pass_end = res_we && at_last;

endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 10,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] res_q [NUM_CH]
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (wr_ch == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        res_q[g] <= '0;
      else if (slot_en)
        res_q[g] <= wr_val;
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int DATA_W  = 10,
  parameter int NUM_TMR = 2,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 1,
  localparam int RD_W   = (DATA_W > CTRL_W) ? DATA_W : CTRL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CTRL_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [RD_W-1:0]    rd_data,
  input  logic [NUM_TMR-1:0] tmr_trig,
  input  logic               ext_trig,
  output logic               cnv_req,
  output logic [CH_W-1:0]    cnv_ch,
  input  logic               cnv_done,
  input  logic [DATA_W-1:0]  cnv_data,
  output logic               irq
);

  logic [1:0]        rst_sync_q;
  logic              rst_ns;
  logic              ctrl_wr, trig_any;
  logic              start_q, flag_q, aclr_q;
  logic              busy, pass_end, res_we;
  cfg_t              cfg_q;
  logic [CTRL_W-1:0] ctrl_rd;
  logic [DATA_W-1:0] res_q [NUM_CH];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= '0;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  assign ctrl_wr  = wr_en && (wr_addr == '0);
  assign trig_any = (|tmr_trig) | ext_trig;
  assign aclr_q   = cfg_q.aclr;

  adc_scan_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_ns),
    .ctrl_wr  (ctrl_wr),
    .wr_data  (wr_data),
    .trig_any (trig_any),
    .busy     (busy),
    .pass_end (pass_end),
    .start_q  (start_q),
    .flag_q   (flag_q),
    .cfg_q    (cfg_q),
    .ctrl_rd  (ctrl_rd)
  );

  adc_scan_fsm #(.CH_W(CH_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_ns),
    .start_q  (start_q),
    .cfg_q    (cfg_q),
    .cnv_done (cnv_done),
    .cnv_req  (cnv_req),
    .cnv_ch   (cnv_ch),
    .busy     (busy),
    .pass_end (pass_end),
    .res_we   (res_we)
  );

  adc_scan_results #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_res (
    .clk    (clk),
    .rst_n  (rst_ns),
    .we     (res_we),
    .wr_ch  (cnv_ch),
    .wr_val (cnv_data),
    .res_q  (res_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr[ADDR_W-1])
      rd_data = RD_W'(res_q[rd_addr[CH_W-1:0]]);
    else if (rd_addr[CH_W-1:0] == '0)
      rd_data = RD_W'(ctrl_rd);
  end

  assign irq = flag_q & cfg_q.irq_en;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_ns,
  input logic            cnv_req,
  input logic [CH_W-1:0] cnv_ch,
  input logic            busy,
  input logic            pass_end,
  input logic            res_we,
  input logic            start_q,
  input logic            flag_q,
  input logic            aclr_q,
  input logic            irq
);

  // R12: a request never lasts more than one cycle
  p_req_single_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    cnv_req |=> !cnv_req);

  // R4: a stored non-final result is followed at once by the next channel's request
  p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (res_we && !pass_end) |=> (cnv_req && (cnv_ch == CH_W'($past(cnv_ch) + 1'b1))));

  // R7: completion of the last channel sets the flag
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    pass_end |=> flag_q);

  // R7: no interrupt without the flag
  p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    irq |-> flag_q);

  // R8: auto-clear drops start and stops the sequencer
  p_autoclr_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (pass_end && aclr_q) |=> (!start_q && !busy));

  // R10: start cannot be set again while a pass runs
  p_busy_no_set_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && !start_q) |=> !start_q);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .cnv_req  (cnv_req),
  .cnv_ch   (cnv_ch),
  .busy     (busy),
  .pass_end (pass_end),
  .res_we   (res_we),
  .start_q  (start_q),
  .flag_q   (flag_q),
  .aclr_q   (aclr_q),
  .irq      (irq)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_addr, rd_addr;
  logic [9:0] wr_data, rd_data;
  logic [1:0] tmr_trig;
  logic       ext_trig;
  logic       cnv_req, cnv_done, irq;
  logic [2:0] cnv_ch;
  logic [9:0] cnv_data;

  int checks = 0;
  int fails  = 0;

  // converter model state
  int         lat = 1;
  int         pend = 0;
  int         log_n = 0;
  int         req_total = 0;
  logic [2:0] log_ch [64];
  logic [9:0] pend_data;
  logic [9:0] exp_res [8];

  always #(CLK_P/2) clk = ~clk;

  adc_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tmr_trig(tmr_trig), .ext_trig(ext_trig),
    .cnv_req(cnv_req), .cnv_ch(cnv_ch), .cnv_done(cnv_done), .cnv_data(cnv_data),
    .irq(irq)
  );

  // converter core model, acting on falling edges
  always @(negedge clk) begin
    cnv_done = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        cnv_done = 1'b1;
        cnv_data = pend_data;
      end
    end
    if (cnv_req) begin
      pend_data = {cnv_ch, 7'(req_total)};
      exp_res[cnv_ch] = pend_data;
      req_total++;
      if (log_n < 64) log_ch[log_n] = cnv_ch;
      log_n++;
      pend = lat;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic rd(input logic [3:0] a, output logic [9:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  function automatic logic [9:0] mk(logic st, logic fl, logic ie, logic ac,
                                    logic [1:0] md, logic [1:0] gr, logic [1:0] ct);
    return {ct, gr, md, ac, ie, fl, st};
  endfunction

  task automatic wr_ctrl(input logic [9:0] d);
    tick();
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wait_flag(input int max_cyc, input string tag);
    logic [9:0] v;
    v = '0;
    for (int i = 0; i < max_cyc; i++) begin
      tick();
      rd(4'd0, v);
      if (v[1]) break;
    end
    chk(tag, 32'(v[1]), 1);
  endtask

  task automatic t_reset();
    logic [9:0] v;
    rd(4'd0, v);
    chk("R1 control word", 32'(v), 0);
    for (int c = 0; c < 8; c++) begin
      rd(4'(8 + c), v);
      chk("R1 result reg", 32'(v), 0);
    end
    chk("R1 irq", 32'(irq), 0);
    chk("R1 cnv_req", 32'(cnv_req), 0);
  endtask

  task automatic t_first_timing();
    logic [9:0] v;
    lat = 3; log_n = 0;
    tick();
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = mk(1, 0, 0, 1, 2'b10, 2'b00, 2'd3);
    tick();
    wr_en = 1'b0;
    chk("R2 no request one cycle after write", 32'(cnv_req), 0);
    tick();
    chk("R2 request two cycles after write", 32'(cnv_req), 1);
    chk("R2 first channel is base", 32'(cnv_ch), 0);
    wait_flag(200, "R12 long latency pass completes");
    chk("R4 four channels", log_n, 4);
    for (int i = 0; i < 4; i++) chk("R4 ascending from 0", 32'(log_ch[i]), i);
    for (int c = 0; c < 4; c++) begin
      rd(4'(8 + c), v);
      chk("R6 result stored", 32'(v), 32'(exp_res[c]));
    end
  endtask

  task automatic t_group_hi();
    logic [9:0] v;
    lat = 1; log_n = 0;
    wr_ctrl(mk(1, 0, 1, 1, 2'b10, 2'b01, 2'd2));
    for (int i = 0; i < 100 && log_n < 2; i++) tick();
    rd(4'd0, v);
    chk("R7 no flag before last channel", 32'(v[1]), 0);
    chk("R7 no irq before last channel", 32'(irq), 0);
    wait_flag(100, "R7 flag after last channel");
    chk("R7 irq with enable", 32'(irq), 1);
    rd(4'd0, v);
    chk("R8 start cleared", 32'(v[0]), 0);
    repeat (20) tick();
    chk("R8 no further requests", log_n, 3);
    for (int i = 0; i < 3; i++) chk("R4 group 1 order", 32'(log_ch[i]), 4 + i);
    for (int c = 4; c < 7; c++) begin
      rd(4'(8 + c), v);
      chk("R6 upper group result", 32'(v), 32'(exp_res[c]));
    end
    wr_ctrl(mk(0, 0, 1, 1, 2'b10, 2'b01, 2'd2));
    rd(4'd0, v);
    chk("R11 write 0 clears flag", 32'(v[1]), 0);
    chk("R11 irq drops", 32'(irq), 0);
    wr_ctrl(mk(0, 1, 1, 1, 2'b10, 2'b01, 2'd2));
    rd(4'd0, v);
    chk("R11 write 1 does not set flag", 32'(v[1]), 0);
  endtask

  task automatic t_single();
    lat = 2; log_n = 0;
    wr_ctrl(mk(1, 0, 0, 1, 2'b00, 2'b01, 2'd3));
    wait_flag(100, "R5 single pass completes");
    repeat (20) tick();
    chk("R5 one conversion", log_n, 1);
    chk("R5 base channel only", 32'(log_ch[0]), 4);
  endtask

  task automatic t_triggers();
    for (int s = 0; s < 3; s++) begin
      lat = 1;
      wr_ctrl(mk(0, 0, 0, 1, 2'b10, 2'b00, 2'd0));
      log_n = 0;
      tick();
      if (s == 0) tmr_trig = 2'b01;
      else if (s == 1) tmr_trig = 2'b10;
      else ext_trig = 1'b1;
      tick();
      tmr_trig = 2'b00; ext_trig = 1'b0;
      wait_flag(100, "R3 trigger starts scan");
      chk("R3 one channel converted", log_n, 1);
      chk("R3 channel 0", 32'(log_ch[0]), 0);
      chk("R7 no irq when disabled", 32'(irq), 0);
    end
  endtask

  task automatic t_busy();
    logic [9:0] v;
    lat = 20; log_n = 0;
    wr_ctrl(mk(0, 0, 0, 1, 2'b10, 2'b00, 2'd3));
    wr_ctrl(mk(1, 0, 0, 1, 2'b10, 2'b00, 2'd3));
    repeat (5) tick();
    ext_trig = 1'b1; tmr_trig = 2'b11;
    tick();
    ext_trig = 1'b0; tmr_trig = 2'b00;
    wr_ctrl(mk(0, 0, 0, 1, 2'b10, 2'b00, 2'd3));
    wr_ctrl(mk(1, 0, 0, 1, 2'b10, 2'b01, 2'd0));
    rd(4'd0, v);
    chk("R10 start write ignored while busy", 32'(v[0]), 0);
    wait_flag(400, "R10 pass completes");
    repeat (60) tick();
    chk("R10 no restart", log_n, 4);
    for (int i = 0; i < 4; i++) chk("R10 channels unchanged", 32'(log_ch[i]), i);
  endtask

  task automatic t_repeat();
    logic [9:0] v;
    int n0;
    lat = 1;
    wr_ctrl(mk(0, 0, 0, 0, 2'b10, 2'b00, 2'd1));
    log_n = 0;
    wr_ctrl(mk(1, 0, 0, 0, 2'b10, 2'b00, 2'd1));
    for (int i = 0; i < 200 && log_n < 5; i++) tick();
    rd(4'd0, v);
    chk("R9 start stays set", 32'(v[0]), 1);
    chk("R9 flag set after a pass", 32'(v[1]), 1);
    wr_ctrl(mk(0, 0, 0, 0, 2'b10, 2'b00, 2'd1));
    repeat (30) tick();
    n0 = log_n;
    chk("R9 current pass completes", n0 % 2, 0);
    for (int i = 0; i < n0 && i < 64; i++) chk("R9 repeated order", 32'(log_ch[i]), i % 2);
    repeat (20) tick();
    chk("R9 no new pass after clear", log_n, n0);
    rd(4'd0, v);
    chk("R9 start reads 0", 32'(v[0]), 0);
    chk("R9 flag from final pass", 32'(v[1]), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    tmr_trig = '0; ext_trig = 1'b0; cnv_done = 1'b0; cnv_data = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_first_timing();
    t_group_hi();
    t_single();
    t_triggers();
    t_busy();
    t_repeat();
    summary();
    $finish;
  end

endmodule